// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a processor bus and compares every valid bus cycle against two programmed breakpoint channels. Each channel holds an address, an encoded address-ignore selector, an address-space tag with an optional ignore bit, and a qualifier. The qualifier restricts matches by access size, by direction (read or write) and by kind (instruction fetch or data access). The second channel can also compare the bus data through a per-bit mask. When a channel condition holds, the block raises a one-cycle break request for the debug logic. Alongside it, the block reports whether an instruction break should be taken before or after the instruction executes.

A shared control register selects how the two channels combine. In independent mode either channel raises a break. In sequential mode the first channel only arms the second, and the second fires only once it is armed. The control register also holds two sticky flags that record channel hits. Software programs the block through a simple write port. Every register can be read back through a combinational read port.

Top module: `bus_break_unit`

## Requirements
- R1: After reset every register reads zero and `brk_req` and `brk_after` are low.
- R2: Register offsets on `reg_addr` are: 0 A address, 1 A mask, 2 A tag, 3 A qualifier, 4 B address, 5 B mask, 6 B tag, 7 B qualifier, 8 B data, 9 B data mask, 10 control. Unused offsets read zero. The mask register keeps bits 3:0, the qualifier keeps bits 6:0, and the control register keeps bits 3, 6, 7, 10, 14 and 15.
- R3: Mask bits {3,1,0} select which low address bits are ignored: 000 none, 001 low 10, 010 low 12, 011 all, 100 low 16, 101 low 20. Codes 110 and 111 compare all bits.
- R4: A channel matches only when `bus_asid` equals its tag, unless bit 2 of its mask register is set.
- R5: Qualifier bits {6,1,0} select the size: 000 any size, 001 byte (`bus_size`=0), 010 16-bit (1), 011 32-bit (2), 100 64-bit (3). Other codes never match.
- R6: Qualifier bit 2 enables reads and bit 3 enables writes (`bus_write`=1). Both may be set. With both clear the channel never matches.
- R7: Qualifier bit 4 enables instruction fetches (`bus_ifetch`=1) and bit 5 enables data accesses. Both may be set. With both clear the channel never matches.
- R8: With control bit 3 clear, a match on either channel in a valid bus cycle makes `brk_req` high for exactly the following cycle.
- R9: With control bit 3 set, a channel A match raises no break and arms channel B. A channel B match raises a break only while armed. The armed state clears when B fires or when the control register is written.
- R10: With control bit 7 set, channel B also requires `bus_data` to equal its data register in every bit where the data mask is 0.
- R11: `brk_after` is high with `brk_req` when a firing channel's hit was an instruction fetch and that channel's after bit is set (bit 10 for A, bit 6 for B). Otherwise it is low.
- R12: Control bit 15 (A) and bit 14 (B) are set by a counted hit of that channel. A control write with the bit at 0 clears it, a write of 1 does not set it, and a hit in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | 32 | Bus address |
| bus_asid | input | 8 | Bus address-space tag |
| bus_data | input | 32 | Bus data |
| bus_size | input | 2 | Access size code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| brk_req | output | 1 | Break request pulse |
| brk_after | output | 1 | Break after execution |

## Verification
A wrong armed state shows up on the first channel B match that follows. Either a break appears in sequential mode without a preceding A hit, or it is missing after one, one cycle after the bus cycle. Corrupted sticky flags show up at once on a control read-back. A mis-decoded address or qualifier field shows up as a missing or extra `brk_req` in the cycle after the probing bus cycle. The bench therefore probes each field with one access just inside its boundary and one just outside it.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_A = 0;
  localparam int unsigned CH_B = 1;

  // register offsets
  localparam logic [3:0] OFF_CH_STRIDE = 4'd4;
  localparam logic [3:0] OFF_ADDR  = 4'd0;
  localparam logic [3:0] OFF_MASK  = 4'd1;
  localparam logic [3:0] OFF_TAG   = 4'd2;
  localparam logic [3:0] OFF_QUAL  = 4'd3;
  localparam logic [3:0] OFF_BDATA = 4'd8;
  localparam logic [3:0] OFF_BDMSK = 4'd9;
  localparam logic [3:0] OFF_CTL   = 4'd10;

  // control bit positions
  localparam int unsigned CB_SEQ     = 3;
  localparam int unsigned CB_B_AFTER = 6;
  localparam int unsigned CB_B_DATA  = 7;
  localparam int unsigned CB_A_AFTER = 10;
  localparam int unsigned CB_B_FLAG  = 14;
  localparam int unsigned CB_A_FLAG  = 15;

  localparam int unsigned MASK_W = 4;
  localparam int unsigned QUAL_W = 7;

  // number of low address bits ignored for a selector code
  function automatic int unsigned ign_bits(input logic [2:0] code, input int unsigned aw);
    case (code)
      3'b001:  ign_bits = 10;
      3'b010:  ign_bits = 12;
      3'b011:  ign_bits = aw;
      3'b100:  ign_bits = 16;
      3'b101:  ign_bits = 20;
      default: ign_bits = 0;
    endcase
  endfunction

  function automatic logic size_match(input logic [2:0] sel, input logic [1:0] sz);
    case (sel)
      3'b000:  size_match = 1'b1;
      3'b001:  size_match = (sz == 2'd0);
      3'b010:  size_match = (sz == 2'd1);
      3'b011:  size_match = (sz == 2'd2);
      3'b100:  size_match = (sz == 2'd3);
      default: size_match = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bbu_rst_sync.sv
module bbu_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_out_n = hold_q;
endmodule

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned REG_W  = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [3:0]                         addr,
  input  logic [REG_W-1:0]                   wdata,
  output logic [REG_W-1:0]                   rdata,
  input  logic                               flag_a,
  input  logic                               flag_b,
  output logic [NCH-1:0][ADDR_W-1:0]         ch_addr,
  output logic [NCH-1:0][MASK_W-1:0]         ch_mask,
  output logic [NCH-1:0][TAG_W-1:0]          ch_tag,
  output logic [NCH-1:0][QUAL_W-1:0]         ch_qual,
  output logic [DATA_W-1:0]                  b_data,
  output logic [DATA_W-1:0]                  b_dmask,
  output logic                               seq_mode,
  output logic                               a_after,
  output logic                               b_after,
  output logic                               b_data_en,
  output logic                               ctl_we
);
  for (genvar i = 0; i < NCH; i++) begin : g_chreg
    localparam logic [3:0] BASE = OFF_CH_STRIDE * 4'(i);
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic [TAG_W-1:0]  tag_q,  tag_d;
    logic [QUAL_W-1:0] qual_q, qual_d;
    logic              sel_addr, sel_mask, sel_tag, sel_qual;

    assign sel_addr = we && (addr == BASE + OFF_ADDR);
    assign sel_mask = we && (addr == BASE + OFF_MASK);
    assign sel_tag  = we && (addr == BASE + OFF_TAG);
    assign sel_qual = we && (addr == BASE + OFF_QUAL);

    always_comb begin
      addr_d = addr_q;
      mask_d = mask_q;
      tag_d  = tag_q;
      qual_d = qual_q;
      if (sel_addr) addr_d = wdata[ADDR_W-1:0];
      if (sel_mask) mask_d = wdata[MASK_W-1:0];
      if (sel_tag)  tag_d  = wdata[TAG_W-1:0];
      if (sel_qual) qual_d = wdata[QUAL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        mask_q <= '0;
        tag_q  <= '0;
        qual_q <= '0;
      end else begin
        addr_q <= addr_d;
        mask_q <= mask_d;
        tag_q  <= tag_d;
        qual_q <= qual_d;
      end
    end

    assign ch_addr[i] = addr_q;
    assign ch_mask[i] = mask_q;
    assign ch_tag[i]  = tag_q;
    assign ch_qual[i] = qual_q;
  end

  logic [DATA_W-1:0] dat_q, dat_d, dmsk_q, dmsk_d;
  logic [3:0]        ctl_q, ctl_d;   // {a_after, b_data, b_after, seq}
  logic              sel_dat, sel_dmsk;

  assign sel_dat  = we && (addr == OFF_BDATA);
  assign sel_dmsk = we && (addr == OFF_BDMSK);
  assign ctl_we   = we && (addr == OFF_CTL);

  always_comb begin
    dat_d  = dat_q;
    dmsk_d = dmsk_q;
    ctl_d  = ctl_q;
    if (sel_dat)  dat_d  = wdata[DATA_W-1:0];
    if (sel_dmsk) dmsk_d = wdata[DATA_W-1:0];
    if (ctl_we)   ctl_d  = {wdata[CB_A_AFTER], wdata[CB_B_DATA], wdata[CB_B_AFTER], wdata[CB_SEQ]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dmsk_q <= '0;
      ctl_q  <= '0;
    end else begin
      dat_q  <= dat_d;
      dmsk_q <= dmsk_d;
      ctl_q  <= ctl_d;
    end
  end

  assign b_data    = dat_q;
  assign b_dmask   = dmsk_q;
  assign seq_mode  = ctl_q[0];
  assign b_after   = ctl_q[1];
  assign b_data_en = ctl_q[2];
  assign a_after   = ctl_q[3];

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_ADDR:                  rdata[ADDR_W-1:0] = ch_addr[CH_A];
      OFF_MASK:                  rdata[MASK_W-1:0] = ch_mask[CH_A];
      OFF_TAG:                   rdata[TAG_W-1:0]  = ch_tag[CH_A];
      OFF_QUAL:                  rdata[QUAL_W-1:0] = ch_qual[CH_A];
      OFF_CH_STRIDE + OFF_ADDR:  rdata[ADDR_W-1:0] = ch_addr[CH_B];
      OFF_CH_STRIDE + OFF_MASK:  rdata[MASK_W-1:0] = ch_mask[CH_B];
      OFF_CH_STRIDE + OFF_TAG:   rdata[TAG_W-1:0]  = ch_tag[CH_B];
      OFF_CH_STRIDE + OFF_QUAL:  rdata[QUAL_W-1:0] = ch_qual[CH_B];
      OFF_BDATA:                 rdata[DATA_W-1:0] = dat_q;
      OFF_BDMSK:                 rdata[DATA_W-1:0] = dmsk_q;
      OFF_CTL: begin
        rdata[CB_SEQ]     = ctl_q[0];
        rdata[CB_B_AFTER] = ctl_q[1];
        rdata[CB_B_DATA]  = ctl_q[2];
        rdata[CB_A_AFTER] = ctl_q[3];
        rdata[CB_B_FLAG]  = flag_b;
        rdata[CB_A_FLAG]  = flag_a;
      end
      default: rdata = '0;
    endcase
  end

  // R2: the control register changes only through a control write
  a_r2_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));
endmodule

// File: rtl/bbu_chan.sv
module bbu_chan
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 8
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TAG_W-1:0]  bus_asid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        bus_size,
  input  logic              bus_write,
  input  logic              bus_ifetch,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [TAG_W-1:0]  cfg_tag,
  input  logic [QUAL_W-1:0] cfg_qual,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_dmask,
  input  logic              data_en,
  output logic              hit
);
  logic [2:0]        amode;
  int unsigned       ign;
  logic [ADDR_W-1:0] care;
  logic addr_ok, tag_ok, size_ok, dir_ok, kind_ok, data_ok;

  assign amode = {cfg_mask[3], cfg_mask[1], cfg_mask[0]};
  assign ign   = ign_bits(amode, ADDR_W);

  always_comb begin
    for (int b = 0; b < int'(ADDR_W); b++) begin
      care[b] = (b >= int'(ign));
    end
  end

  assign addr_ok = ((bus_addr ^ cfg_addr) & care) == '0;
  assign tag_ok  = cfg_mask[2] || (bus_asid == cfg_tag);
  assign size_ok = size_match({cfg_qual[6], cfg_qual[1], cfg_qual[0]}, bus_size);
  assign dir_ok  = bus_write  ? cfg_qual[3] : cfg_qual[2];
  assign kind_ok = bus_ifetch ? cfg_qual[4] : cfg_qual[5];
  assign data_ok = !data_en || (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);

  assign hit = bus_valid && addr_ok && tag_ok && size_ok && dir_ok && kind_ok && data_ok;
endmodule

// File: rtl/bbu_flow.sv
module bbu_flow
  import bbu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           bus_ifetch,
  input  logic           seq_mode,
  input  logic           a_after,
  input  logic           b_after,
  input  logic           ctl_we,
  input  logic           wflag_a,
  input  logic           wflag_b,
  output logic           brk_req,
  output logic           brk_after,
  output logic           flag_a,
  output logic           flag_b
);
  logic fire_a, count_b, fire;
  logic armed_q, armed_d;
  logic req_q, req_d, aft_q, aft_d;
  logic fa_q, fa_d, fb_q, fb_d;

  assign fire_a  = hit[CH_A] && !seq_mode;
  assign count_b = hit[CH_B] && (!seq_mode || armed_q);
  assign fire    = fire_a || count_b;

  always_comb begin
    req_d = fire;
    aft_d = bus_ifetch && ((fire_a && a_after) || (count_b && b_after));

    armed_d = armed_q;
    if (seq_mode && hit[CH_A])  armed_d = 1'b1;
    else if (ctl_we)            armed_d = 1'b0;
    else if (count_b)           armed_d = 1'b0;

    fa_d = fa_q;
    if (ctl_we && !wflag_a) fa_d = 1'b0;
    if (hit[CH_A])          fa_d = 1'b1;

    fb_d = fb_q;
    if (ctl_we && !wflag_b) fb_d = 1'b0;
    if (count_b)            fb_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      aft_q   <= 1'b0;
      armed_q <= 1'b0;
      fa_q    <= 1'b0;
      fb_q    <= 1'b0;
    end else begin
      req_q   <= req_d;
      aft_q   <= aft_d;
      armed_q <= armed_d;
      fa_q    <= fa_d;
      fb_q    <= fb_d;
    end
  end

  assign brk_req   = req_q;
  assign brk_after = aft_q;
  assign flag_a    = fa_q;
  assign flag_b    = fb_q;

  a_r12_flag_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_q && !ctl_we) |=> fa_q);
  a_r12_flag_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q && !ctl_we) |=> fb_q);
  a_r11_after_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    aft_q |-> req_q);
  a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed_q) |=> !req_q);
  a_r8_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (fa_q || fb_q));
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TAG_W-1:0]  bus_asid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        bus_size,
  input  logic              bus_write,
  input  logic              bus_ifetch,
  output logic              brk_req,
  output logic              brk_after
);
  logic                       srst_n;
  logic [NCH-1:0][ADDR_W-1:0] ch_addr;
  logic [NCH-1:0][MASK_W-1:0] ch_mask;
  logic [NCH-1:0][TAG_W-1:0]  ch_tag;
  logic [NCH-1:0][QUAL_W-1:0] ch_qual;
  logic [DATA_W-1:0]          b_data, b_dmask;
  logic                       seq_mode, a_after, b_after, b_data_en, ctl_we;
  logic                       flag_a, flag_b;
  logic [NCH-1:0]             hit;

  bbu_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (srst_n)
  );

  bbu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .ch_addr   (ch_addr),
    .ch_mask   (ch_mask),
    .ch_tag    (ch_tag),
    .ch_qual   (ch_qual),
    .b_data    (b_data),
    .b_dmask   (b_dmask),
    .seq_mode  (seq_mode),
    .a_after   (a_after),
    .b_after   (b_after),
    .b_data_en (b_data_en),
    .ctl_we    (ctl_we)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit USE_DATA = (i == CH_B);
    logic den;
    assign den = USE_DATA ? b_data_en : 1'b0;

    bbu_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ch (
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_asid   (bus_asid),
      .bus_data   (bus_data),
      .bus_size   (bus_size),
      .bus_write  (bus_write),
      .bus_ifetch (bus_ifetch),
      .cfg_addr   (ch_addr[i]),
      .cfg_mask   (ch_mask[i]),
      .cfg_tag    (ch_tag[i]),
      .cfg_qual   (ch_qual[i]),
      .cfg_data   (b_data),
      .cfg_dmask  (b_dmask),
      .data_en    (den),
      .hit        (hit[i])
    );

    // R6: a hit needs the direction of the access enabled in the qualifier
    a_r6_dir_enabled: assert property (@(posedge clk) disable iff (!srst_n)
      hit[i] |-> (bus_write ? ch_qual[i][3] : ch_qual[i][2]));
    // R7: a hit needs the kind of the access enabled in the qualifier
    a_r7_kind_enabled: assert property (@(posedge clk) disable iff (!srst_n)
      hit[i] |-> (bus_ifetch ? ch_qual[i][4] : ch_qual[i][5]));
  end

  bbu_flow u_flow (
    .clk        (clk),
    .rst_n      (srst_n),
    .hit        (hit),
    .bus_ifetch (bus_ifetch),
    .seq_mode   (seq_mode),
    .a_after    (a_after),
    .b_after    (b_after),
    .ctl_we     (ctl_we),
    .wflag_a    (reg_wdata[CB_A_FLAG]),
    .wflag_b    (reg_wdata[CB_B_FLAG]),
    .brk_req    (brk_req),
    .brk_after  (brk_after),
    .flag_a     (flag_a),
    .flag_b     (flag_b)
  );

  // R8: a break in independent mode follows a hit one cycle earlier
  a_r8_req_from_hit: assert property (@(posedge clk) disable iff (!srst_n)
    (brk_req && !$past(seq_mode)) |-> $past(|hit));
endmodule

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [7:0]  bus_asid;
  logic [31:0] bus_data;
  logic [1:0]  bus_size;
  logic        bus_write;
  logic        bus_ifetch;
  logic        brk_req;
  logic        brk_after;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bus_break_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_data(bus_data),
    .bus_size(bus_size), .bus_write(bus_write), .bus_ifetch(bus_ifetch),
    .brk_req(brk_req), .brk_after(brk_after)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read offset %0d", a), reg_rdata, exp);
  endtask

  task automatic bus(input logic [31:0] a, input logic [7:0] t, input logic [31:0] d,
                     input logic [1:0] sz, input logic w, input logic f,
                     output logic r, output logic af);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_asid = t; bus_data = d;
    bus_size = sz; bus_write = w; bus_ifetch = f;
    @(negedge clk);
    r = brk_req; af = brk_after;
    bus_valid = 1'b0;
  endtask

  task automatic hit_chk(input string req, input logic [31:0] a, input logic [7:0] t,
                         input logic [31:0] d, input logic [1:0] sz, input logic w,
                         input logic f, input logic exp);
    logic r, af;
    bus(a, t, d, sz, w, f, r, af);
    chk(req, $sformatf("brk_req addr 0x%08h", a), {31'd0, r}, {31'd0, exp});
  endtask

  task automatic cfg(input int ch, input logic [31:0] a, input logic [3:0] m,
                     input logic [7:0] t, input logic [6:0] q);
    logic [3:0] base;
    base = (ch == 0) ? 4'd0 : 4'd4;
    wr(base + 4'd0, a);
    wr(base + 4'd1, {28'd0, m});
    wr(base + 4'd2, {24'd0, t});
    wr(base + 4'd3, {25'd0, q});
  endtask

  task automatic clean();
    wr(4'd3, 32'd0);
    wr(4'd7, 32'd0);
    wr(4'd10, 32'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 12; i++) rd_chk("R1", 4'(i), 32'd0);
    chk("R1", "brk_req after reset", {31'd0, brk_req}, 32'd0);
    chk("R1", "brk_after after reset", {31'd0, brk_after}, 32'd0);
  endtask

  task automatic t_regs();
    wr(4'd0, 32'hA5A5_1234); rd_chk("R2", 4'd0, 32'hA5A5_1234);
    wr(4'd1, 32'hFFFF_FFFF); rd_chk("R2", 4'd1, 32'h0000_000F);
    wr(4'd2, 32'h0000_01C3); rd_chk("R2", 4'd2, 32'h0000_00C3);
    wr(4'd7, 32'hFFFF_FFFF); rd_chk("R2", 4'd7, 32'h0000_007F);
    wr(4'd8, 32'hDEAD_BEEF); rd_chk("R2", 4'd8, 32'hDEAD_BEEF);
    wr(4'd9, 32'h0F0F_00FF); rd_chk("R2", 4'd9, 32'h0F0F_00FF);
    wr(4'd11, 32'hFFFF_FFFF); rd_chk("R2", 4'd11, 32'd0);
    // R12: writing ones to the flag bits does not set them
    wr(4'd10, 32'hFFFF_FFFF); rd_chk("R12", 4'd10, 32'h0000_04C8);
    rd_chk("R2", 4'd0, 32'hA5A5_1234);
    clean();
  endtask

  task automatic t_addr_mask();
    clean();
    cfg(0, 32'h1234_5678, 4'h4, 8'h00, 7'h3C);       // compare all
    hit_chk("R3", 32'h1234_5678, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1234_5679, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h1234_5678, 4'h5, 8'h00, 7'h3C);       // low 10
    hit_chk("R3", 32'h1234_5400, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1234_57FF, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1234_5800, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h1234_5678, 4'h6, 8'h00, 7'h3C);       // low 12
    hit_chk("R3", 32'h1234_5000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1234_6000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h1234_5678, 4'hC, 8'h00, 7'h3C);       // low 16
    hit_chk("R3", 32'h1234_FFFF, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1235_0000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h1234_5678, 4'hD, 8'h00, 7'h3C);       // low 20
    hit_chk("R3", 32'h123F_FFFF, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R3", 32'h1240_0000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h1234_5678, 4'h7, 8'h00, 7'h3C);       // all ignored
    hit_chk("R3", 32'hDEAD_BEEF, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_tag();
    clean();
    cfg(0, 32'h0000_1000, 4'h0, 8'h5A, 7'h3C);
    hit_chk("R4", 32'h0000_1000, 8'h5A, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R4", 32'h0000_1000, 8'h5B, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h0000_1000, 4'h4, 8'h5A, 7'h3C);
    hit_chk("R4", 32'h0000_1000, 8'h5B, 0, 2'd2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_size();
    clean();
    cfg(0, 32'h0000_2000, 4'h4, 8'h00, 7'h3E);       // 16-bit
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd1, 1'b0, 1'b0, 1'b1);
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h0000_2000, 4'h4, 8'h00, 7'h7C);       // 64-bit
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd3, 1'b0, 1'b0, 1'b1);
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h0000_2000, 4'h4, 8'h00, 7'h3D);       // byte
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd0, 1'b0, 1'b0, 1'b1);
    cfg(0, 32'h0000_2000, 4'h4, 8'h00, 7'h3C);       // any size
    hit_chk("R5", 32'h0000_2000, 8'h00, 0, 2'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_dir();
    clean();
    cfg(0, 32'h0000_3000, 4'h4, 8'h00, 7'h34);       // read only
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b1, 1'b0, 1'b0);
    cfg(0, 32'h0000_3000, 4'h4, 8'h00, 7'h38);       // write only
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b1, 1'b0, 1'b1);
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h0000_3000, 4'h4, 8'h00, 7'h30);       // neither
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    hit_chk("R6", 32'h0000_3000, 8'h00, 0, 2'd2, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_kind();
    clean();
    cfg(0, 32'h0000_4000, 4'h4, 8'h00, 7'h1C);       // fetch only
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b1, 1'b1);
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    cfg(0, 32'h0000_4000, 4'h4, 8'h00, 7'h2C);       // data only
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b1, 1'b0);
    cfg(0, 32'h0000_4000, 4'h4, 8'h00, 7'h0C);       // neither
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b1, 1'b0);
    hit_chk("R7", 32'h0000_4000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_indep();
    clean();
    cfg(0, 32'h0000_A000, 4'h4, 8'h00, 7'h3C);
    cfg(1, 32'h0000_B000, 4'h4, 8'h00, 7'h3C);
    hit_chk("R8", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8", "pulse is one cycle", {31'd0, brk_req}, 32'd0);
    hit_chk("R8", 32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R8", 32'h0000_C000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_seq();
    clean();
    cfg(0, 32'h0000_A000, 4'h4, 8'h00, 7'h3C);
    cfg(1, 32'h0000_B000, 4'h4, 8'h00, 7'h3C);
    wr(4'd10, 32'h0000_0008);
    hit_chk("R9", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    hit_chk("R9", 32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    hit_chk("R9", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    hit_chk("R9", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    hit_chk("R9", 32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
    wr(4'd10, 32'h0000_0008);
    hit_chk("R9", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_data();
    clean();
    cfg(1, 32'h0000_D000, 4'h4, 8'h00, 7'h3C);
    wr(4'd8, 32'hCAFE_0000);
    wr(4'd9, 32'h0000_FFFF);
    wr(4'd10, 32'h0000_0080);
    hit_chk("R10", 32'h0000_D000, 8'h00, 32'hCAFE_1234, 2'd2, 1'b1, 1'b0, 1'b1);
    hit_chk("R10", 32'h0000_D000, 8'h00, 32'hCAFF_0000, 2'd2, 1'b1, 1'b0, 1'b0);
    wr(4'd10, 32'h0000_0000);
    hit_chk("R10", 32'h0000_D000, 8'h00, 32'hCAFF_0000, 2'd2, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_after();
    logic r, af;
    clean();
    cfg(0, 32'h0000_A000, 4'h4, 8'h00, 7'h3C);
    cfg(1, 32'h0000_B000, 4'h4, 8'h00, 7'h3C);
    wr(4'd10, 32'h0000_0400);
    bus(32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b1, r, af);
    chk("R11", "A fetch after", {30'd0, r, af}, 32'd3);
    bus(32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b0, r, af);
    chk("R11", "A data hit", {30'd0, r, af}, 32'd2);
    bus(32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b1, r, af);
    chk("R11", "B fetch, A after only", {30'd0, r, af}, 32'd2);
    wr(4'd10, 32'h0000_0040);
    bus(32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b1, r, af);
    chk("R11", "B fetch after", {30'd0, r, af}, 32'd3);
    bus(32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b1, r, af);
    chk("R11", "A fetch before", {30'd0, r, af}, 32'd2);
  endtask

  task automatic t_flags();
    clean();
    rd_chk("R12", 4'd10, 32'd0);
    cfg(0, 32'h0000_A000, 4'h4, 8'h00, 7'h3C);
    cfg(1, 32'h0000_B000, 4'h4, 8'h00, 7'h3C);
    hit_chk("R12", 32'h0000_A000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    rd_chk("R12", 4'd10, 32'h0000_8000);
    wr(4'd10, 32'h0000_8000);
    rd_chk("R12", 4'd10, 32'h0000_8000);
    hit_chk("R12", 32'h0000_B000, 8'h00, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    rd_chk("R12", 4'd10, 32'h0000_C000);
    wr(4'd10, 32'h0000_4000);
    rd_chk("R12", 4'd10, 32'h0000_4000);
    wr(4'd10, 32'h0000_0000);
    rd_chk("R12", 4'd10, 32'h0000_0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_asid = '0; bus_data = '0;
    bus_size = '0; bus_write = 1'b0; bus_ifetch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_addr_mask();
    t_tag();
    t_size();
    t_dir();
    t_kind();
    t_indep();
    t_seq();
    t_data();
    t_after();
    t_flags();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule